// File: doc/BRIEF.md
# Latched Serial Read Port with Recirculating Output

This block is one read port of a sequential video memory. A memory cycle delivers a wide word of sixteen 12-bit samples. When the memory-cycle strobe falls with this port's mode code selected, the port captures that word into a holding latch. When the port's own transfer strobe falls, the latch is copied into an output register and a new 16-sample block begins. Each shift enable then steps to the next sample. The latch separates the memory side from the serial side, so the next memory read can land while the current block is still being shifted out.

If no new transfer arrives after 16 shifts, the output register wraps around and the same block repeats. An output enable gates the data, the valid flag and a drive-enable bit that stands in for a three-state pad. The port also raises a flag when a transfer falls on, or shortly after, a latch load. A chip uses two instances, each with its own shift clock and its own mode code, to give two independent read ports.

Both strobes are active low and act on their falling edge. A strobe counts only after it has been seen high at least once since reset.

Top module: `vsp_read_port`

## Requirements
- R1: While reset is high and on the first edge after it, `smp_data` is 0 and `smp_valid` and `xfer_collide` are 0. During reset `smp_drive` is also 0.
- R2: A falling `mem_stb_n` loads `mem_word` into the latch only when `mem_mode` equals `PORT_MODE`. The mode codes are 2'b00 (read to port A, the default), 2'b01 (read to port B), 2'b10 (write) and 2'b11 (refresh). With any other mode the latch keeps its contents.
- R3: A falling `xfer_n` copies the latch into the output register and restarts the block. The edge after that presents entry 0, which occupies bits [11:0] of the word, with `smp_first` high.
- R4: Each cycle with `shift_en` high advances the output by one entry in ascending order; entry i is bits [12*i+11:12*i]. Without `shift_en` the presented sample holds.
- R5: After entry 15 the next shift presents entry 0 again with `smp_first` high, so the block repeats.
- R6: With `out_en` low at an edge, the following cycle has `smp_data` = 0, `smp_valid` = 0 and `smp_drive` = 0. Shifting continues underneath.
- R7: When a latch load and a transfer fall on the same edge, the transfer takes the old latch contents and `xfer_collide` pulses for one cycle.
- R8: A transfer within `GUARD_CYC` (default 2) edges after a latch load also pulses `xfer_collide`. That transfer takes the newly loaded word.
- R9: A transfer in the middle of a block restarts it at entry 0.
- R10: `smp_valid` stays low until the first transfer after reset has completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock of this port |
| rst | input | 1 | Synchronous active-high reset |
| mem_stb_n | input | 1 | Memory-cycle strobe; its falling edge loads the latch |
| mem_mode | input | 2 | Mode code of the memory cycle |
| mem_word | input | 192 | Word from the memory array, entry i at bits [12*i+11:12*i] |
| xfer_n | input | 1 | Read-transfer strobe; its falling edge moves the latch to the output register |
| shift_en | input | 1 | Advance to the next sample |
| out_en | input | 1 | Output enable |
| smp_data | output | 12 | Presented sample, 0 when disabled |
| smp_valid | output | 1 | Sample is valid |
| smp_drive | output | 1 | Pad drive enable |
| smp_first | output | 1 | Presented sample is entry 0 of the block |
| xfer_collide | output | 1 | Transfer fell inside the guard window of a load |

## Verification
A strobe fall acts on the edge where the low level is first sampled. The sample that results from a transfer or a shift shows up one edge later, because the outputs are registered. `xfer_collide` is registered on the same edge as the offending transfer, and the effect of `out_en` appears on the next edge. The bench changes inputs on the falling clock edge and reads outputs on the next falling edge, so every check sees exactly one rising edge. Its expected samples follow that one-edge lag.

// File: rtl/vsp_pkg.sv
package vsp_pkg;
  // Mode code carried with each memory cycle ({M1,M0})
  typedef enum logic [1:0] {
    MODE_RD_A = 2'b00,
    MODE_RD_B = 2'b01,
    MODE_WR   = 2'b10,
    MODE_RFSH = 2'b11
  } xfer_mode_e;
endpackage

// File: rtl/vsp_fall_det.sv
module vsp_fall_det #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] fall
);
  logic [N-1:0] prev_q;

  // prev resets low: a strobe must be seen high before its fall counts
  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= lvl;
  end

  assign fall = prev_q & ~lvl;
endmodule

// File: rtl/vsp_hold_latch.sv
module vsp_hold_latch #(
  parameter int WORD_BITS = 192
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 load,
  input  logic [WORD_BITS-1:0] din,
  output logic [WORD_BITS-1:0] dout
);
  always_ff @(posedge clk) begin
    if (rst)       dout <= '0;
    else if (load) dout <= din;
  end

  AST_LATCH_KEEP: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(dout)); // R2
  AST_LATCH_TAKE: assert property (@(posedge clk) disable iff (rst)
    load |=> dout == $past(din)); // R2
endmodule

// File: rtl/vsp_recirc_shifter.sv
module vsp_recirc_shifter #(
  parameter int SAMPLE_W = 12,
  parameter int DEPTH    = 16,
  localparam int WORD_BITS = SAMPLE_W * DEPTH,
  localparam int PW        = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 xfer,
  input  logic [WORD_BITS-1:0] word_in,
  input  logic                 shift,
  output logic [SAMPLE_W-1:0]  sample,
  output logic                 is_first
);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [SAMPLE_W-1:0] ent [DEPTH];
  logic [SAMPLE_W-1:0] blk_q [DEPTH];
  logic [PW-1:0]       pos_q;

  for (genvar i = 0; i < DEPTH; i++) begin : g_unpack
    assign ent[i] = word_in[i*SAMPLE_W +: SAMPLE_W];

    always_ff @(posedge clk) begin
      if (rst)       blk_q[i] <= '0;
      else if (xfer) blk_q[i] <= ent[i];
    end
  end

  // Read index wraps instead of draining: the block recirculates
  always_ff @(posedge clk) begin
    if (rst)        pos_q <= '0;
    else if (xfer)  pos_q <= '0;
    else if (shift) pos_q <= (pos_q == LAST) ? '0 : pos_q + 1'b1;
  end

  assign sample   = blk_q[pos_q];
  assign is_first = (pos_q == '0);

  AST_XFER_HOME: assert property (@(posedge clk) disable iff (rst)
    xfer |=> is_first); // R3
  AST_STEP_WRAP: assert property (@(posedge clk) disable iff (rst)
    (shift && !xfer && pos_q == LAST) |=> is_first); // R5
  AST_HOLD_POS: assert property (@(posedge clk) disable iff (rst)
    (!shift && !xfer) |=> $stable(pos_q)); // R4
endmodule

// File: rtl/vsp_guard.sv
module vsp_guard #(
  parameter int GUARD_CYC = 2,
  localparam int CW = $clog2(GUARD_CYC + 2)
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic xfer,
  output logic collide
);
  logic [CW-1:0] cnt_q;
  logic          hit;

  always_ff @(posedge clk) begin
    if (rst)              cnt_q <= '0;
    else if (load)        cnt_q <= CW'(GUARD_CYC);
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign hit = xfer && (load || cnt_q != '0);

  always_ff @(posedge clk) begin
    if (rst) collide <= 1'b0;
    else     collide <= hit;
  end

  AST_COLLIDE_CAUSE: assert property (@(posedge clk) disable iff (rst)
    collide |-> $past(xfer)); // R7
  AST_SAME_EDGE: assert property (@(posedge clk) disable iff (rst)
    (load && xfer) |=> collide); // R7
endmodule

// File: rtl/vsp_read_port.sv
module vsp_read_port
  import vsp_pkg::*;
#(
  parameter int         SAMPLE_W  = 12,
  parameter int         DEPTH     = 16,
  parameter int         GUARD_CYC = 2,
  parameter xfer_mode_e PORT_MODE = MODE_RD_A,
  localparam int WORD_BITS = SAMPLE_W * DEPTH
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 mem_stb_n,
  input  logic [1:0]           mem_mode,
  input  logic [WORD_BITS-1:0] mem_word,
  input  logic                 xfer_n,
  input  logic                 shift_en,
  input  logic                 out_en,
  output logic [SAMPLE_W-1:0]  smp_data,
  output logic                 smp_valid,
  output logic                 smp_drive,
  output logic                 smp_first,
  output logic                 xfer_collide
);
  logic [1:0]           falls;
  logic                 ld_hit;
  logic                 xf_hit;
  logic [WORD_BITS-1:0] latch_w;
  logic [SAMPLE_W-1:0]  cur_smp;
  logic                 cur_first;
  logic                 primed_q;

  vsp_fall_det #(.N(2)) u_edges (
    .clk (clk),
    .rst (rst),
    .lvl ({xfer_n, mem_stb_n}),
    .fall(falls)
  );

  assign ld_hit = falls[0] && (xfer_mode_e'(mem_mode) == PORT_MODE);
  assign xf_hit = falls[1];

  vsp_hold_latch #(.WORD_BITS(WORD_BITS)) u_latch (
    .clk (clk),
    .rst (rst),
    .load(ld_hit),
    .din (mem_word),
    .dout(latch_w)
  );

  vsp_recirc_shifter #(.SAMPLE_W(SAMPLE_W), .DEPTH(DEPTH)) u_shift (
    .clk     (clk),
    .rst     (rst),
    .xfer    (xf_hit),
    .word_in (latch_w),
    .shift   (shift_en),
    .sample  (cur_smp),
    .is_first(cur_first)
  );

  vsp_guard #(.GUARD_CYC(GUARD_CYC)) u_guard (
    .clk    (clk),
    .rst    (rst),
    .load   (ld_hit),
    .xfer   (xf_hit),
    .collide(xfer_collide)
  );

  // Registered output stage
  always_ff @(posedge clk) begin
    if (rst) begin
      primed_q  <= 1'b0;
      smp_data  <= '0;
      smp_valid <= 1'b0;
      smp_drive <= 1'b0;
      smp_first <= 1'b0;
    end else begin
      if (xf_hit) primed_q <= 1'b1;
      smp_data  <= out_en ? cur_smp : '0;
      smp_valid <= out_en && primed_q;
      smp_drive <= out_en;
      smp_first <= cur_first;
    end
  end

  AST_QUIET_OFF: assert property (@(posedge clk) disable iff (rst)
    !smp_drive |-> (smp_data == '0 && !smp_valid)); // R6
  AST_OE_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    !out_en |=> !smp_drive); // R6
  AST_FIRST_SHOWN: assert property (@(posedge clk) disable iff (rst)
    xf_hit |=> ##1 smp_first); // R3
  AST_VALID_PRIMED: assert property (@(posedge clk) disable iff (rst)
    (smp_valid && !$past(smp_valid)) |-> primed_q); // R10
endmodule

// File: tb/test_vsp_read_port.sv
`timescale 1ns/1ps
module test_vsp_read_port;
  localparam int SW = 12;
  localparam int DP = 16;
  localparam int WB = SW * DP;

  logic          clk = 1'b0;
  logic          rst;
  logic          mem_stb_n, xfer_n, shift_en, out_en;
  logic [1:0]    mem_mode;
  logic [WB-1:0] mem_word;
  logic [SW-1:0] smp_data;
  logic          smp_valid, smp_drive, smp_first, xfer_collide;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  vsp_read_port i_vsp_read_port (
    .clk(clk), .rst(rst), .mem_stb_n(mem_stb_n), .mem_mode(mem_mode),
    .mem_word(mem_word), .xfer_n(xfer_n), .shift_en(shift_en), .out_en(out_en),
    .smp_data(smp_data), .smp_valid(smp_valid), .smp_drive(smp_drive),
    .smp_first(smp_first), .xfer_collide(xfer_collide)
  );

  function automatic logic [SW-1:0] pat(input int s, input int i);
    return {s[3:0], 4'hA, i[3:0]};
  endfunction

  function automatic logic [WB-1:0] mk_word(input int s);
    logic [WB-1:0] w;
    for (int i = 0; i < DP; i++) w[i*SW +: SW] = pat(s, i);
    return w;
  endfunction

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic load_latch(input logic [1:0] md, input int s);
    mem_mode = md; mem_word = mk_word(s); mem_stb_n = 1'b0;
    tick();
    mem_stb_n = 1'b1;
    tick();
  endtask

  // {xfer_n, shift_en, out_en, exp_first, exp_valid, exp_data[11:0]}
  localparam logic [16:0] TBL [11] = '{
    {1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 12'h000},
    {1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 12'h000},
    {1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 12'h1A0},
    {1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 12'h1A1},
    {1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 12'h1A2},
    {1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 12'h1A2},
    {1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 12'h000},
    {1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 12'h1A3},
    {1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 12'h1A4},
    {1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 12'h1A4},
    {1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 12'h1A0}
  };

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; mem_stb_n = 1'b1; xfer_n = 1'b1; shift_en = 1'b0;
    out_en = 1'b1; mem_mode = 2'b00; mem_word = '0;
    tick(); tick();
    // R1: reset state
    chk("R1 data in reset", 32'(smp_data), 0);
    chk("R1 drive in reset", 32'(smp_drive), 0);
    chk("R1 valid in reset", 32'(smp_valid), 0);
    chk("R1 collide in reset", 32'(xfer_collide), 0);
    rst = 1'b0;
    tick();
    chk("R1 data after reset", 32'(smp_data), 0);
    chk("R1 valid after reset", 32'(smp_valid), 0);

    load_latch(2'b00, 1);

    // Table: R3/R4/R6/R9/R10
    for (int r = 0; r < 11; r++) begin
      xfer_n = TBL[r][16]; shift_en = TBL[r][15]; out_en = TBL[r][14];
      tick();
      chk($sformatf("R3/R4/R9 data row %0d", r), 32'(smp_data), 32'(TBL[r][11:0]));
      chk($sformatf("R5/R3 first row %0d", r), 32'(smp_first), 32'(TBL[r][13]));
      chk($sformatf("R10/R6 valid row %0d", r), 32'(smp_valid), 32'(TBL[r][12]));
      chk($sformatf("R6 drive row %0d", r), 32'(smp_drive), 32'(TBL[r][14]));
    end
    xfer_n = 1'b1; shift_en = 1'b0; out_en = 1'b1;
    tick();

    // R2: load with another mode code is ignored
    load_latch(2'b01, 5);
    tick();
    xfer_n = 1'b0; tick();
    chk("R2 no collide on foreign mode", 32'(xfer_collide), 0);
    xfer_n = 1'b1; tick();
    chk("R2 latch kept on foreign mode", 32'(smp_data), 32'(pat(1, 0)));

    // R4/R5: two full rounds of continuous shifting
    shift_en = 1'b1;
    for (int k = 0; k < 2 * DP; k++) begin
      tick();
      chk($sformatf("R4 shift sample %0d", k), 32'(smp_data), 32'(pat(1, k % DP)));
      chk($sformatf("R5 wrap first %0d", k), 32'(smp_first), 32'((k % DP) == 0));
    end
    shift_en = 1'b0;

    // R7: load and transfer on the same edge
    load_latch(2'b00, 2);
    tick(); tick(); tick();
    mem_word = mk_word(3); mem_stb_n = 1'b0; xfer_n = 1'b0;
    tick();
    chk("R7 collide on same edge", 32'(xfer_collide), 1);
    mem_stb_n = 1'b1; xfer_n = 1'b1;
    tick();
    chk("R7 transfer took old latch", 32'(smp_data), 32'(pat(2, 0)));
    chk("R7 collide is one pulse", 32'(xfer_collide), 0);

    // R8: transfer two edges after the load is inside the guard window
    xfer_n = 1'b0; tick();
    chk("R8 collide inside window", 32'(xfer_collide), 1);
    xfer_n = 1'b1; tick();
    chk("R8 transfer took new latch", 32'(smp_data), 32'(pat(3, 0)));
    chk("R8 first after late transfer", 32'(smp_first), 1);

    // R8: outside the window no flag
    tick(); tick();
    xfer_n = 1'b0; tick();
    chk("R8 no collide outside window", 32'(xfer_collide), 0);
    xfer_n = 1'b1; tick();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule